// File: doc/BRIEF.md
# Crosspoint Routing Configuration Register

This block stores the routing setup for a crosspoint with 16 outputs and 16 inputs. Every output owns a 5-bit slot made of an enable flag and a 4-bit source number. The slots sit in a first-rank register of 80 bits. That register can be filled in two ways. In serial mode it works as a shift register fed one bit at a time, and its top stage drives a chain output so that several blocks can be programmed from one data line. In parallel mode an output number and a 5-bit value overwrite a single slot, so one route can change without reloading the rest.

A second rank holds the configuration that actually drives the switches. It follows the first rank while the update strobe and the chip enable are both low. At all other times it keeps its contents, so a new setup can be prepared in the background and applied to every output in one step. The second rank is decoded into a 256-bit vector of switch enables, with at most one enable per output row. An active-low clear input disables every output at once. It does not touch the source numbers or the first rank.

All strobes are sampled by a fast system clock `clk_i`. The serial clock and the update strobe are treated as synchronous level inputs, and the serial shift acts on a detected falling edge of `sclk_i`.

Top module: `xbar_cfg_regs`

## Requirements
- R1: The slot of output k occupies first-rank bits [5k+4:5k]. Bit 5k+4 is the enable flag, and bits 5k+3..5k hold the source number with its MSB at 5k+3. The parallel data word `pdata_i` has the same layout: bit 4 is the enable and bits 3..0 the source.
- R2: With `ser_mode_i`=1 and `ce_n_i`=0, each `clk_i` edge that samples `sclk_i` low, after it was sampled high on the previous edge, shifts the first rank up by one place and loads `sdata_i` into bit 0.
- R3: Shifting 80 bits in programs the whole first rank. The first bit sent becomes the enable of output 15, followed by output 15's source MSB-first, then output 14, and so on down to the source LSB of output 0.
- R4: `chain_o` always equals first-rank bit 79, in both modes, so a bit sent on `sdata_i` appears on `chain_o` after 80 serial shifts.
- R5: With `ser_mode_i`=0 and `ce_n_i`=0, every `clk_i` edge that samples `sclk_i` low writes `pdata_i` into the slot addressed by `addr_i`. All other slots are left as they are, and nothing is written while `sclk_i` is high.
- R6: On each `clk_i` edge where `upd_n_i`=0 and `ce_n_i`=0, the second rank takes the value the first rank held before that edge. Otherwise the second rank holds. `rank2_o` shows the second rank in the first-rank layout.
- R7: `clr_n_i`=0 clears every second-rank enable flag at once, without waiting for a clock edge, and keeps them cleared while it stays low, even when an update is requested. Second-rank source numbers and the whole first rank are not changed.
- R8: While `ce_n_i`=1, no shift, no slot write and no update takes place.
- R9: For each output k, `out_en_o[k]` equals its second-rank enable. When it is 1, exactly one switch bit, `sw_en_o[16k+source]`, is set in row k (`sw_en_o[16k+15:16k]`). When it is 0, row k is all zero, whatever the source number holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples all strobes |
| ser_mode_i | input | 1 | 1 = serial shift loading, 0 = addressed slot writes |
| sclk_i | input | 1 | Serial shift clock / parallel write strobe (active low) |
| sdata_i | input | 1 | Serial data in |
| ce_n_i | input | 1 | Active-low chip enable for loading and update |
| upd_n_i | input | 1 | Active-low update: second rank follows first rank |
| clr_n_i | input | 1 | Active-low asynchronous clear of all output enables |
| addr_i | input | 4 | Output slot selected for a parallel write |
| pdata_i | input | 5 | Parallel slot value: bit 4 enable, bits 3..0 source |
| chain_o | output | 1 | Top stage of the first rank, used for daisy chaining |
| sw_en_o | output | 256 | One-hot-per-row switch enables, bit 16*output+source |
| out_en_o | output | 16 | Per-output enable from the second rank |
| rank2_o | output | 80 | Second-rank contents in slot layout |

## Verification
The assertions check on every clock several properties. The switch vector never holds more than one set bit per row, and a row is non-empty exactly when its output is enabled. The second rank does not move while the update strobe or the chip enable is high, and it copies the previous first-rank value when both are low. All enables read zero whenever the clear is low. Other behaviour can only be shown by the directed scenarios: the serial bit order and which output each bit lands in, the 80-shift delay to the chain output, that a level write hits only the addressed slot, that the clear acts between clock edges and leaves the first rank intact, and that a blocked chip enable leaves the chain output unchanged.

// File: rtl/xbar_cfg_pkg.sv
package xbar_cfg_pkg;

    localparam int OUTS    = 16;
    localparam int INS     = 16;
    localparam int SEL_W   = $clog2(INS);
    localparam int SLOT_W  = SEL_W + 1;
    localparam int CHAIN_W = OUTS * SLOT_W;
    localparam int ADDR_W  = $clog2(OUTS);
    localparam int SW_W    = OUTS * INS;

    // One output's routing entry: enable flag above the source number.
    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] sel;
    } slot_t;

    typedef logic [CHAIN_W-1:0] chain_t;

    typedef enum logic {
        LOAD_PAR = 1'b0,
        LOAD_SER = 1'b1
    } load_mode_e;

    function automatic slot_t slot_at(input chain_t v, input int k);
        return slot_t'(v[k*SLOT_W +: SLOT_W]);
    endfunction

endpackage

// File: rtl/xbar_cfg_rank1.sv
module xbar_cfg_rank1
    import xbar_cfg_pkg::*;
(
    input  logic              clk_i,
    input  load_mode_e        mode_i,
    input  logic              sclk_i,
    input  logic              sdata_i,
    input  logic              ce_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  slot_t             pdata_i,
    output chain_t            r1_o
);

    logic   sclk_q;
    logic   shift_fire;
    logic   slot_fire;
    chain_t r1_q;
    chain_t r1_d;

    // R2: a shift needs a high-then-low pair of samples of the serial clock
    assign shift_fire = !ce_n_i && (mode_i == LOAD_SER) && sclk_q && !sclk_i;
    // R5: level-sensitive slot write while the strobe is low
    assign slot_fire  = !ce_n_i && (mode_i == LOAD_PAR) && !sclk_i;

    always_comb begin
        r1_d = r1_q;
        if (shift_fire) begin
            r1_d = {r1_q[CHAIN_W-2:0], sdata_i};
        end else if (slot_fire) begin
            r1_d[int'(addr_i)*SLOT_W +: SLOT_W] = pdata_i;
        end
    end

    always_ff @(posedge clk_i) begin
        sclk_q <= sclk_i;
        r1_q   <= r1_d;
    end

    assign r1_o = r1_q;

endmodule

// File: rtl/xbar_cfg_rank2.sv
module xbar_cfg_rank2
    import xbar_cfg_pkg::*;
(
    input  logic   clk_i,
    input  logic   clr_n_i,
    input  logic   load_i,
    input  chain_t r1_i,
    output chain_t r2_o
);

    for (genvar k = 0; k < OUTS; k++) begin : g_slot
        slot_t src;
        logic             en_q;
        logic [SEL_W-1:0] sel_q;

        assign src = slot_at(r1_i, k);

        // R7: only the enable flag has the asynchronous clear
        always_ff @(posedge clk_i or negedge clr_n_i) begin
            if (!clr_n_i) begin
                en_q <= 1'b0;
            end else if (load_i) begin
                en_q <= src.en;
            end
        end

        always_ff @(posedge clk_i) begin
            if (load_i) begin
                sel_q <= src.sel;
            end
        end

        assign r2_o[k*SLOT_W +: SLOT_W] = {en_q, sel_q};
    end

endmodule

// File: rtl/xbar_cfg_decode.sv
module xbar_cfg_decode
    import xbar_cfg_pkg::*;
(
    input  chain_t          cfg_i,
    output logic [SW_W-1:0] sw_o,
    output logic [OUTS-1:0] oen_o
);

    for (genvar k = 0; k < OUTS; k++) begin : g_row
        slot_t s;
        logic [INS-1:0] row;

        assign s = slot_at(cfg_i, k);

        // R9: disabled rows stay dark regardless of the source number
        always_comb begin
            row = '0;
            if (s.en) begin
                row[s.sel] = 1'b1;
            end
        end

        assign sw_o[k*INS +: INS] = row;
        assign oen_o[k]           = s.en;
    end

endmodule

// File: rtl/xbar_cfg_regs.sv
module xbar_cfg_regs
    import xbar_cfg_pkg::*;
(
    input  logic                        clk_i,
    input  logic                        ser_mode_i,
    input  logic                        sclk_i,
    input  logic                        sdata_i,
    input  logic                        ce_n_i,
    input  logic                        upd_n_i,
    input  logic                        clr_n_i,
    input  logic [3:0]                  addr_i,
    input  logic [4:0]                  pdata_i,
    output logic                        chain_o,
    output logic [255:0]                sw_en_o,
    output logic [15:0]                 out_en_o,
    output logic [79:0]                 rank2_o
);

    chain_t     r1_q;
    chain_t     r2_q;
    load_mode_e mode;
    logic       upd_fire;

    assign mode     = load_mode_e'(ser_mode_i);
    // R6 / R8: the second rank loads only with both strobes low
    assign upd_fire = !upd_n_i && !ce_n_i;

    xbar_cfg_rank1 u_rank1 (
        .clk_i   (clk_i),
        .mode_i  (mode),
        .sclk_i  (sclk_i),
        .sdata_i (sdata_i),
        .ce_n_i  (ce_n_i),
        .addr_i  (addr_i),
        .pdata_i (slot_t'(pdata_i)),
        .r1_o    (r1_q)
    );

    xbar_cfg_rank2 u_rank2 (
        .clk_i   (clk_i),
        .clr_n_i (clr_n_i),
        .load_i  (upd_fire),
        .r1_i    (r1_q),
        .r2_o    (r2_q)
    );

    xbar_cfg_decode u_dec (
        .cfg_i (r2_q),
        .sw_o  (sw_en_o),
        .oen_o (out_en_o)
    );

    // R4: chain output is the top first-rank stage in either mode
    assign chain_o = r1_q[CHAIN_W-1];
    assign rank2_o = r2_q;

endmodule

// File: rtl/xbar_cfg_chk.sv
module xbar_cfg_chk
    import xbar_cfg_pkg::*;
(
    input logic            clk_i,
    input logic            clr_n_i,
    input logic            ce_n_i,
    input logic            upd_n_i,
    input chain_t          r1_i,
    input chain_t          rank2_o,
    input logic [OUTS-1:0] out_en_o,
    input logic [SW_W-1:0] sw_en_o
);

    for (genvar k = 0; k < OUTS; k++) begin : g_row_chk
        // R9: at most one switch per row, present exactly when enabled
        a_r9_row_onehot: assert property (@(posedge clk_i) disable iff (!clr_n_i)
            $onehot0(sw_en_o[k*INS +: INS]) &&
            (out_en_o[k] == (sw_en_o[k*INS +: INS] != '0)));
    end

    // R9: total lit switches equals number of enabled outputs
    a_r9_switch_count: assert property (@(posedge clk_i) disable iff (!clr_n_i)
        $countones(sw_en_o) == $countones(out_en_o));

    // R6: update high keeps the second rank
    a_r6_hold_no_update: assert property (@(posedge clk_i) disable iff (!clr_n_i)
        upd_n_i |=> $stable(rank2_o));

    // R6: both strobes low copies the previous first rank
    a_r6_transparent: assert property (@(posedge clk_i) disable iff (!clr_n_i)
        (!upd_n_i && !ce_n_i) |=> (rank2_o == $past(r1_i)));

    // R8: chip enable high freezes both ranks
    a_r8_ce_freeze: assert property (@(posedge clk_i) disable iff (!clr_n_i)
        ce_n_i |=> ($stable(r1_i) && $stable(rank2_o)));

    // R7: clear low means no output is enabled
    always @(posedge clk_i) begin
        if (!clr_n_i) begin
            a_r7_clear_disables: assert (out_en_o == '0);
        end
    end

endmodule

bind xbar_cfg_regs xbar_cfg_chk chk_i (
    .clk_i    (clk_i),
    .clr_n_i  (clr_n_i),
    .ce_n_i   (ce_n_i),
    .upd_n_i  (upd_n_i),
    .r1_i     (r1_q),
    .rank2_o  (rank2_o),
    .out_en_o (out_en_o),
    .sw_en_o  (sw_en_o)
);

// File: tb/xbar_cfg_regs_tb_top.sv
module xbar_cfg_regs_tb_top;
    import xbar_cfg_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic         ser_mode, sclk, sdata, ce_n, upd_n, clr_n;
    logic [3:0]   addr;
    logic [4:0]   pdata;
    logic         chain;
    logic [255:0] sw;
    logic [15:0]  oen;
    logic [79:0]  r2;

    xbar_cfg_regs dut_i (
        .clk_i(clk), .ser_mode_i(ser_mode), .sclk_i(sclk), .sdata_i(sdata),
        .ce_n_i(ce_n), .upd_n_i(upd_n), .clr_n_i(clr_n), .addr_i(addr),
        .pdata_i(pdata), .chain_o(chain), .sw_en_o(sw), .out_en_o(oen),
        .rank2_o(r2)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [79:0] m1 = '0;
    logic [79:0] m2 = '0;

    task automatic chk(input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [255:0] exp_sw(input logic [79:0] c);
        logic [255:0] r = '0;
        for (int k = 0; k < 16; k++)
            if (c[k*5+4]) r[k*16 + int'(c[k*5 +: 4])] = 1'b1;
        return r;
    endfunction

    function automatic logic [15:0] en_of(input logic [79:0] c);
        logic [15:0] r;
        for (int k = 0; k < 16; k++) r[k] = c[k*5+4];
        return r;
    endfunction

    function automatic logic [79:0] drop_en(input logic [79:0] c);
        logic [79:0] r = c;
        for (int k = 0; k < 16; k++) r[k*5+4] = 1'b0;
        return r;
    endfunction

    task automatic ser_bit(input logic b);
        @(negedge clk); sdata = b; sclk = 1'b0;
        @(negedge clk); sclk = 1'b1;
        if (!ce_n && ser_mode) m1 = {m1[78:0], b};
    endtask

    task automatic ser_load(input logic [79:0] v);
        ser_mode = 1'b1;
        for (int i = 79; i >= 0; i--) ser_bit(v[i]);
    endtask

    task automatic par_wr(input logic [3:0] a, input logic [4:0] d);
        @(negedge clk); addr = a; pdata = d; sclk = 1'b0;
        @(negedge clk); sclk = 1'b1;
        if (!ce_n && !ser_mode) m1[int'(a)*5 +: 5] = d;
    endtask

    task automatic upd_pulse();
        @(negedge clk); upd_n = 1'b0;
        @(negedge clk); upd_n = 1'b1;
        if (!ce_n) m2 = clr_n ? m1 : drop_en(m1);
    endtask

    task automatic check_state(input string req);
        chk(req, "rank2", r2, m2);
        chk(req, "switch", sw, exp_sw(m2));
        chk(req, "out_en", oen, en_of(m2));
    endtask

    // R7 at start, R1/R3 serial load order, R6 update
    task automatic t_reset_and_serial();
        logic [79:0] pat;
        for (int k = 0; k < 16; k++) pat[k*5 +: 5] = {k != 5, 4'(k) ^ 4'hA};
        repeat (3) @(negedge clk);
        chk("R7", "out_en under clear", oen, '0);
        chk("R7", "switch under clear", sw, '0);
        ser_load(pat);
        upd_pulse();
        chk("R7", "sources loaded, enables held off", r2, drop_en(pat));
        @(negedge clk); clr_n = 1'b1;
        @(negedge clk);
        chk("R6", "no update keeps enables off", oen, '0);
        upd_pulse();
        check_state("R6");
        chk("R3", "first bit is output 15 enable", oen[15], 1'b1);
        chk("R3", "output 15 source 5", sw[15*16 +: 16], 256'(16'h0020));
        chk("R1", "output 0 source 10", sw[0 +: 16], 256'(16'h0400));
        chk("R9", "output 5 disabled row dark", sw[5*16 +: 16], '0);
    endtask

    // R4 chain delay, R2 shifting
    task automatic t_chain();
        logic [79:0] patb;
        int bad = 0;
        for (int k = 0; k < 16; k++) patb[k*5 +: 5] = {k[0] == 1'b0, 4'(15 - k)};
        for (int i = 79; i >= 0; i--) begin
            if (chain !== m1[79]) bad++;
            ser_bit(patb[i]);
        end
        chk("R4", "chain follows top stage over 80 shifts", 256'(bad), '0);
        chk("R2", "shift register after 80 bits", r2, m2);
        ser_mode = 1'b0;
        @(negedge clk);
        chk("R4", "chain in parallel mode", chain, patb[79]);
        upd_pulse();
        chk("R2", "new pattern applied", r2, patb);
        check_state("R2");
    endtask

    // R5 slot writes, level behaviour, R6 transparency
    task automatic t_parallel();
        ser_mode = 1'b0;
        par_wr(4'd3, 5'b1_0110);
        par_wr(4'd0, 5'b1_1111);
        par_wr(4'd15, 5'b1_0000);
        chk("R6", "hold before update", r2, m2);
        upd_pulse();
        check_state("R5");
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); addr = 4'(i * 5); pdata = 5'(i * 7 + 3);
        end
        upd_pulse();
        chk("R5", "strobe high writes nothing", r2, m2);
        @(negedge clk); upd_n = 1'b0;
        par_wr(4'd7, 5'b1_0001);
        @(negedge clk);
        m2 = m1;
        chk("R6", "transparent follow", r2, m2);
        upd_n = 1'b1;
    endtask

    // R8 chip enable blocks everything
    task automatic t_chip_enable();
        logic [79:0] keep1 = m1;
        logic        keepc = chain;
        @(negedge clk); ce_n = 1'b1; ser_mode = 1'b1;
        ser_bit(~keepc); ser_bit(1'b1); ser_bit(1'b0);
        ser_mode = 1'b0;
        par_wr(4'd7, 5'b0_1111);
        upd_pulse();
        chk("R8", "chain unchanged", chain, keepc);
        chk("R8", "rank2 unchanged", r2, m2);
        @(negedge clk); ce_n = 1'b0;
        upd_pulse();
        chk("R8", "first rank untouched", r2, keep1);
    endtask

    // R7 asynchronous clear
    task automatic t_clear();
        @(negedge clk); #5 clr_n = 1'b0;
        #1 chk("R7", "enables drop between edges", oen, '0);
        upd_pulse();
        chk("R7", "update during clear keeps enables off", r2, drop_en(m1));
        @(negedge clk); clr_n = 1'b1;
        @(negedge clk);
        chk("R7", "release does not restore", oen, '0);
        upd_pulse();
        chk("R7", "first rank kept through clear", r2, m1);
    endtask

    // R9 decode corners
    task automatic t_decode();
        ser_mode = 1'b0;
        par_wr(4'd2, 5'b0_1111);
        par_wr(4'd4, 5'b1_0000);
        par_wr(4'd9, 5'b1_1111);
        upd_pulse();
        chk("R9", "disabled row with source 15", sw[2*16 +: 16], '0);
        chk("R9", "source 0", sw[4*16 +: 16], 256'(16'h0001));
        chk("R9", "source 15", sw[9*16 +: 16], 256'(16'h8000));
        check_state("R9");
    endtask

    initial begin
        ser_mode = 1'b1; sclk = 1'b1; sdata = 1'b0; ce_n = 1'b0;
        upd_n = 1'b1; clr_n = 1'b0; addr = '0; pdata = '0;
        t_reset_and_serial();
        t_chain();
        t_parallel();
        t_chip_enable();
        t_clear();
        t_decode();
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule